// File: doc/BRIEF.md
# LPDDR2 Mode-Register Bring-Up Sequencer

This block sits on the controller side of an LPDDR2 memory subsystem. It brings up one or two ranks after power-up by issuing a fixed series of mode-register reads and writes on a request/acknowledge command port. A start pulse launches the run. The block waits until the device reports that its own power-up initialization has finished. It then starts impedance calibration and waits out the calibration interval. After that it programs burst and write-recovery settings, then the refresh coverage, and last of all the read latency. The command that carries the read latency also tells the controller that refresh may be enabled.

The read latency and the dual-rank enable are sampled when the start pulse is accepted. Periodic refresh is held off for the whole run and is released only when every selected rank is done. The physical layer, the DRAM timing engine and the refresh scheduler lie outside this block. Busy and done flags let a power-up controller wait for the sequence to end.

Top module: `lpddr2_mrinit_seq`

## Requirements
- R1: For each rank, the first command is a read of mode register 0 (mr_we=0, mr_addr=0, mr_wdata=0). The read is repeated as long as bit 0 of the returned data (the auto-initialization-busy bit) is 1. All other bits of the returned data are ignored.
- R2: After the first read whose bit 0 is 0, the next command writes 0xFF (calibration-init code) to mode register 10.
- R3: After the cycle in which the register-10 write is acknowledged, mr_req stays low for exactly CLK_MHZ+ZQ_MARGIN+1 cycles. With the defaults this is 55 cycles, which is at least 1 us at 50 MHz.
- R4: After the wait, the next command writes 0x23 to mode register 1. This value selects burst length 8 (bits 2:0 = 011), sequential type (bit 3 = 0), wrap (bit 4 = 0) and write recovery 3 (bits 7:5 = 001). The command after it writes 0x00 to mode register 16, so that refresh covers the full array.
- R5: The last command of each rank writes (read_lat − 2) to mode register 2 with mr_ref_set=1. mr_ref_set is 0 on every other command.
- R6: The whole per-rank series runs on mr_cs=0 first. It then runs on mr_cs=1 only if dual_rank was 1 in the cycle the start was accepted. Later changes of dual_rank or read_lat have no effect on the run.
- R7: refresh_en is 0 after reset and 0 while busy is 1. It rises in the cycle done is 1 and stays 1 until the next accepted start.
- R8: Once mr_req is raised, mr_req and all command fields hold steady until the cycle in which mr_ack is 1. Read data is taken in that cycle.
- R9: busy rises the cycle after an accepted start. done is 1 for exactly one cycle after the final acknowledge, and busy is 0 in that cycle and stays 0 until the next start.
- R10: A start pulse while busy is 1 is ignored. The command series and the single done pulse are unchanged.
- R11: After synchronous reset, busy, done, mr_req, mr_ref_set and refresh_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the bring-up sequence |
| read_lat | input | LATW | Final read latency in clocks, sampled at start |
| dual_rank | input | 1 | Also initialize rank 1, sampled at start |
| mr_req | output | 1 | Mode-register command valid |
| mr_we | output | 1 | 1 = write, 0 = read |
| mr_cs | output | 1 | Target rank |
| mr_addr | output | 8 | Mode-register address |
| mr_wdata | output | 8 | Write data (0 on reads) |
| mr_ref_set | output | 1 | Controller refresh enable carried with this command |
| mr_ack | input | 1 | Command accepted this cycle |
| mr_rdata | input | 8 | Read data, valid with mr_ack |
| refresh_en | output | 1 | Periodic refresh allowed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives a device model that reports auto-initialization busy for several polls. The busy replies also set an unrelated bit in the same byte. This catches a design that gives up polling too early, or one that tests the wrong bit and either hangs or skips the wait. The calibration gap is counted to the exact cycle, so a timer that is off by one, or one that never loads, shows up as a wrong count. The bench also covers the following mistakes:
- Rank 1 must run only when it was requested at start. Both a run that ignores the request and a run that follows a dual-rank enable changed mid-run are caught.
- A latency field that is not reduced by two is caught.
- Refresh released before the last rank is done, or a second done pulse after a start pulse sent mid-run, changes the observed stream.

// File: rtl/lpddr2_mrinit_pkg.sv
package lpddr2_mrinit_pkg;

    localparam int MRD = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_ZQ,
        ST_WAIT,
        ST_BURST,
        ST_SEG,
        ST_LAT
    } step_t;

    typedef struct packed {
        logic           we;
        logic           ref_set;
        logic [MRD-1:0] addr;
        logic [MRD-1:0] data;
    } mr_cmd_t;

    localparam logic [MRD-1:0] ADDR_STATUS  = 8'd0;
    localparam logic [MRD-1:0] ADDR_BURST   = 8'd1;
    localparam logic [MRD-1:0] ADDR_LAT     = 8'd2;
    localparam logic [MRD-1:0] ADDR_CAL     = 8'd10;
    localparam logic [MRD-1:0] ADDR_SEGMASK = 8'd16;

    localparam logic [MRD-1:0] VAL_CAL_INIT = 8'hFF;
    localparam logic [MRD-1:0] VAL_BURST    = 8'h23;
    localparam logic [MRD-1:0] VAL_SEG_ALL  = 8'h00;
    localparam logic [MRD-1:0] AUTO_BUSY_MASK = 8'h01;

    function automatic logic step_issues(input step_t s);
        return (s == ST_POLL) || (s == ST_ZQ) || (s == ST_BURST) ||
               (s == ST_SEG)  || (s == ST_LAT);
    endfunction

endpackage

// File: rtl/mrinit_zq_timer.sv
module mrinit_zq_timer #(
    parameter int CLK_MHZ   = 50,
    parameter int ZQ_MARGIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int LOADV = CLK_MHZ + ZQ_MARGIN;
    localparam int TW    = $clog2(LOADV + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= TW'(LOADV);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/mrinit_cmd_gen.sv
module mrinit_cmd_gen
    import lpddr2_mrinit_pkg::*;
#(
    parameter int LATW = 4
) (
    input  step_t         step,
    input  logic [LATW-1:0] lat,
    output mr_cmd_t       cmd
);
    logic [MRD-1:0] lat_code;

    always_comb begin
        lat_code = MRD'(lat) - MRD'(2);
        cmd      = '0;
        case (step)
            ST_POLL: begin
                cmd.we   = 1'b0;
                cmd.addr = ADDR_STATUS;
            end
            ST_ZQ: begin
                cmd.we   = 1'b1;
                cmd.addr = ADDR_CAL;
                cmd.data = VAL_CAL_INIT;
            end
            ST_BURST: begin
                cmd.we   = 1'b1;
                cmd.addr = ADDR_BURST;
                cmd.data = VAL_BURST;
            end
            ST_SEG: begin
                cmd.we   = 1'b1;
                cmd.addr = ADDR_SEGMASK;
                cmd.data = VAL_SEG_ALL;
            end
            ST_LAT: begin
                cmd.we      = 1'b1;
                cmd.ref_set = 1'b1;
                cmd.addr    = ADDR_LAT;
                cmd.data    = lat_code;
            end
            default: cmd = '0;
        endcase
    end
endmodule

// File: rtl/lpddr2_mrinit_seq.sv
module lpddr2_mrinit_seq
    import lpddr2_mrinit_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int ZQ_MARGIN = 4,
    parameter int LATW      = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [LATW-1:0] read_lat,
    input  logic            dual_rank,
    output logic            mr_req,
    output logic            mr_we,
    output logic            mr_cs,
    output logic [7:0]      mr_addr,
    output logic [7:0]      mr_wdata,
    output logic            mr_ref_set,
    input  logic            mr_ack,
    input  logic [7:0]      mr_rdata,
    output logic            refresh_en,
    output logic            busy,
    output logic            done
);
    step_t           step_q, step_d;
    logic            rank_q, rank_d;
    logic            dual_q;
    logic [LATW-1:0] lat_q;
    logic            done_q, refen_q;
    logic            accept, dev_busy, last_rank, zq_load, zq_expired;
    mr_cmd_t         cmd;

    mrinit_cmd_gen #(.LATW(LATW)) gen_i (
        .step (step_q),
        .lat  (lat_q),
        .cmd  (cmd)
    );

    mrinit_zq_timer #(.CLK_MHZ(CLK_MHZ), .ZQ_MARGIN(ZQ_MARGIN)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .load    (zq_load),
        .expired (zq_expired)
    );

    assign mr_req     = step_issues(step_q);
    assign accept     = mr_req && mr_ack;
    assign dev_busy   = (mr_rdata & AUTO_BUSY_MASK) != '0;
    assign last_rank  = (rank_q == 1'b1) || !dual_q;
    assign zq_load    = (step_q == ST_ZQ) && accept;

    always_comb begin
        step_d = step_q;
        rank_d = rank_q;
        case (step_q)
            ST_IDLE:  if (start) begin
                          step_d = ST_POLL;
                          rank_d = 1'b0;
                      end
            ST_POLL:  if (accept && !dev_busy) step_d = ST_ZQ;
            ST_ZQ:    if (accept) step_d = ST_WAIT;
            ST_WAIT:  if (zq_expired) step_d = ST_BURST;
            ST_BURST: if (accept) step_d = ST_SEG;
            ST_SEG:   if (accept) step_d = ST_LAT;
            ST_LAT:   if (accept) begin
                          if (last_rank) begin
                              step_d = ST_IDLE;
                          end else begin
                              step_d = ST_POLL;
                              rank_d = 1'b1;
                          end
                      end
            default:  step_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_IDLE;
            rank_q  <= 1'b0;
            dual_q  <= 1'b0;
            lat_q   <= '0;
            done_q  <= 1'b0;
            refen_q <= 1'b0;
        end else begin
            step_q <= step_d;
            rank_q <= rank_d;
            done_q <= 1'b0;
            if (step_q == ST_IDLE && start) begin
                dual_q  <= dual_rank;
                lat_q   <= read_lat;
                refen_q <= 1'b0;
            end
            if (step_q == ST_LAT && accept && last_rank) begin
                done_q  <= 1'b1;
                refen_q <= 1'b1;
            end
        end
    end

    assign mr_we      = cmd.we;
    assign mr_cs      = rank_q;
    assign mr_addr    = cmd.addr;
    assign mr_wdata   = cmd.data;
    assign mr_ref_set = cmd.ref_set;
    assign refresh_en = refen_q;
    assign busy       = (step_q != ST_IDLE);
    assign done       = done_q;
endmodule

// File: rtl/lpddr2_mrinit_chk.sv
module lpddr2_mrinit_chk #(
    parameter int CLK_MHZ   = 50,
    parameter int ZQ_MARGIN = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       dual_rank,
    input logic       mr_req,
    input logic       mr_we,
    input logic       mr_cs,
    input logic [7:0] mr_addr,
    input logic [7:0] mr_wdata,
    input logic       mr_ref_set,
    input logic       mr_ack,
    input logic       refresh_en,
    input logic       busy,
    input logic       done
);
    localparam int GAP = CLK_MHZ + ZQ_MARGIN + 1;
    localparam int GW  = $clog2(GAP + 1);

    logic [GW-1:0] gap_left;
    logic          dual_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_left  <= '0;
            dual_seen <= 1'b0;
        end else begin
            if (mr_req && mr_ack && mr_we && mr_addr == 8'd10)
                gap_left <= GW'(GAP);
            else if (gap_left != '0)
                gap_left <= gap_left - 1'b1;
            if (start && !busy)
                dual_seen <= dual_rank;
        end
    end

    // R3
    zq_gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        gap_left != '0 |-> !mr_req);

    // R5
    ref_set_only_lat_chk: assert property (@(posedge clk) disable iff (rst)
        mr_ref_set |-> (mr_req && mr_we && mr_addr == 8'd2));

    // R6
    second_rank_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_req && mr_cs) |-> dual_seen);

    // R7
    refresh_held_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !refresh_en);

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_req && !mr_ack) |=> (mr_req && $stable(mr_we) && $stable(mr_cs) &&
                                 $stable(mr_addr) && $stable(mr_wdata)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && refresh_en));

endmodule

bind lpddr2_mrinit_seq lpddr2_mrinit_chk #(
    .CLK_MHZ   (CLK_MHZ),
    .ZQ_MARGIN (ZQ_MARGIN)
) chk_i (.*);

// File: tb/lpddr2_mrinit_seq_tb.sv
module lpddr2_mrinit_seq_tb_top;
    localparam int CLK_MHZ   = 50;
    localparam int ZQ_MARGIN = 4;
    localparam int GAP_EXP   = CLK_MHZ + ZQ_MARGIN + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] read_lat = 4'd6;
    logic       dual_rank = 1'b0;
    logic       mr_req, mr_we, mr_cs, mr_ref_set;
    logic [7:0] mr_addr, mr_wdata;
    logic       mr_ack = 1'b0;
    logic [7:0] mr_rdata = 8'h00;
    logic       refresh_en, busy, done;

    int vectors = 0;
    int errors  = 0;

    always #10ns clk = ~clk;

    lpddr2_mrinit_seq #(.CLK_MHZ(CLK_MHZ), .ZQ_MARGIN(ZQ_MARGIN), .LATW(4)) dut_i (
        .clk(clk), .rst(rst), .start(start), .read_lat(read_lat),
        .dual_rank(dual_rank), .mr_req(mr_req), .mr_we(mr_we), .mr_cs(mr_cs),
        .mr_addr(mr_addr), .mr_wdata(mr_wdata), .mr_ref_set(mr_ref_set),
        .mr_ack(mr_ack), .mr_rdata(mr_rdata), .refresh_en(refresh_en),
        .busy(busy), .done(done)
    );

    // {we, cs, ref_set, addr, data}
    logic [18:0] exp_q[$];
    int ack_delay = 0;
    int polls_left[2];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_rank(input bit cs, input int busy_polls, input int lat);
        for (int i = 0; i <= busy_polls; i++)
            exp_q.push_back({1'b0, cs, 1'b0, 8'd0, 8'd0});        // R1
        exp_q.push_back({1'b1, cs, 1'b0, 8'd10, 8'hFF});          // R2
        exp_q.push_back({1'b1, cs, 1'b0, 8'd1, 8'h23});           // R4
        exp_q.push_back({1'b1, cs, 1'b0, 8'd16, 8'h00});          // R4
        exp_q.push_back({1'b1, cs, 1'b1, 8'd2, 8'(lat - 2)});     // R5
    endtask

    // device model and monitor
    int         wait_left = -1;
    logic [18:0] held;
    bit         gap_on = 0;
    int         gap = 0;
    always @(negedge clk) begin
        if (gap_on) begin
            if (!mr_req) gap++;
            else begin
                chk(gap == GAP_EXP, "R3 calibration gap", gap, GAP_EXP);
                gap_on = 0;
            end
        end
        if (mr_ack) begin
            mr_ack = 1'b0;
            wait_left = -1;
        end else if (mr_req) begin
            if (wait_left < 0) begin
                wait_left = ack_delay;
                held = {mr_we, mr_cs, mr_ref_set, mr_addr, mr_wdata};
            end
            if (wait_left == 0) begin
                logic [18:0] got;
                got = {mr_we, mr_cs, mr_ref_set, mr_addr, mr_wdata};
                chk(got == held, "R8 held command", got, held);
                chk(!refresh_en && busy, "R7 refresh held in run", refresh_en, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R6/R10 unexpected command", got, 0);
                end else begin
                    logic [18:0] e;
                    e = exp_q.pop_front();
                    chk(got == e, "R1/R2/R4/R5/R6 command", got, e);
                end
                if (!mr_we) begin
                    if (polls_left[mr_cs] > 0) begin
                        polls_left[mr_cs]--;
                        mr_rdata = 8'h81;
                    end else mr_rdata = 8'h80;
                end else mr_rdata = 8'h00;
                if (mr_we && mr_addr == 8'd10) begin
                    gap_on = 1;
                    gap = 0;
                end
                mr_ack = 1'b1;
            end else wait_left--;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 done seen", done, 1);
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
        chk(refresh_en == 1'b1, "R7 refresh at done", refresh_en, 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        repeat (10) begin
            @(negedge clk);
            chk(!mr_req && !busy && !done, "R9 quiet after done", {mr_req, busy, done}, 0);
        end
        chk(refresh_en == 1'b1, "R7 refresh stays", refresh_en, 1);
        chk(exp_q.size() == 0, "R6 all commands seen", exp_q.size(), 0);
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11
        chk({busy, done, mr_req, mr_ref_set, refresh_en} == 5'b0, "R11 reset state",
            {busy, done, mr_req, mr_ref_set, refresh_en}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Single rank, no busy polls, immediate ack
        ack_delay = 0; polls_left[0] = 0; polls_left[1] = 0;
        read_lat = 4'd6; dual_rank = 1'b0;
        push_rank(1'b0, 0, 6);
        pulse_start();
        chk(refresh_en == 1'b0, "R7 refresh cleared at start", refresh_en, 0);
        wait_done();

        // Dual rank, busy polls, slow acks, start while busy (R10)
        ack_delay = 2; polls_left[0] = 3; polls_left[1] = 1;
        read_lat = 4'd8; dual_rank = 1'b1;
        push_rank(1'b0, 3, 8);
        push_rank(1'b1, 1, 8);
        pulse_start();
        read_lat = 4'd3;
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done();

        // R6: dual_rank raised after start has no effect; latency 3 -> code 1
        ack_delay = 1; polls_left[0] = 2; polls_left[1] = 0;
        read_lat = 4'd3; dual_rank = 1'b0;
        push_rank(1'b0, 2, 3);
        pulse_start();
        dual_rank = 1'b1;
        read_lat = 4'd7;
        wait_done();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule